// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory with byte-wide storage and a 16-bit word address. A bus master selects it with a device byte. That byte carries a fixed 4-bit type code, three bits that must equal the strap inputs, and a read/write flag. For a write, the master sends the word address as two bytes, most significant byte first, followed by data. Data bytes collect in a 128-entry page buffer, and the buffer is written to the array when the stop condition arrives. A self-timed busy period, counted in clock cycles, then begins. While it runs, the slave refuses its device byte, so the master can poll for completion.

Reads return the byte at the internal address pointer and then advance the pointer. This covers current-address reads, random reads (a write that carries only the word address, followed by a repeated start with the read flag) and sequential reads that continue for as long as the master acknowledges. The SCL and SDA inputs pass through two-flop synchronizers. Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. The block drives SDA only through an active-high drive-low enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device byte is {4'b1010, A2..A0, R/W}, sent MSB first. The slave acknowledges it (drives SDA low in the ninth clock) only if bits 7:4 are 1010, bits 3:1 equal `strap_i` and no internal write is in progress. Otherwise it leaves SDA released and ignores every following byte until the next start.
- R2: After a write device byte, the next two bytes are acknowledged and load the 16-bit address pointer, high byte first.
- R3: Each data byte of a write is acknowledged and placed in the page buffer. The array is updated only on a stop. A repeated start discards the buffered bytes.
- R4: During a write, only the low 7 pointer bits advance and they wrap within the page. The upper 9 bits stay fixed, so a byte past the page end lands at the start of the same page.
- R5: If `wp_i` is high when the stop arrives, no array location changes and no busy period starts. Data bytes are still acknowledged.
- R6: A committed write starts a busy period of WRITE_CYCLES clock cycles. During that period the device byte is not acknowledged. Afterwards it is acknowledged again.
- R7: A read sends the byte at the pointer and then increments it, wrapping from 0xFFFF to 0x0000. A current-address read continues from where the last access left the pointer.
- R8: A random read is an address-only write followed by a repeated start with R/W = 1. It returns the byte at the given address.
- R9: A sequential read sends consecutive bytes while the master acknowledges. A master no-acknowledge ends the transfer and SDA is released.
- R10: Out of reset, and whenever the slave is in standby, the drive-low enable is 0. The enable is set only while the synchronized SCL is low.
- R11: The array holds 2^STORE_AW bytes, addressed by the low STORE_AW bits of the 16-bit pointer (2048 bytes by default). Word addresses 0xFFFF and 0x07FF therefore reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Device address straps compared with bits 3:1 of the device byte |
| wp_i | input | 1 | Write protect, high blocks all array updates |
| sda_drive_low | output | 1 | When 1 the pad pulls SDA low, otherwise SDA is released |

## Verification
The bench writes a single byte, a page write that runs past the page end, and a write that is ended by a repeated start instead of a stop. Reading back the neighbouring addresses shows whether the pointer wraps only within the page and whether the array changes only on a stop. A write under write protect, followed by an immediate poll, shows that data is still acknowledged but neither the array nor the busy state changes. Reads at 0xFFFF and at its alias 0x07FF, with current-address and sequential reads after them, separate the pointer's post-increment and its 16-bit wrap from the narrower array index.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int STORE_AW = 11,
  parameter int WRITE_CYCLES = 5000,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_drive_low
);
  localparam int PAGE_AW = 7;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int STORE_BYTES = 1 << STORE_AW;
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] rx, tx;
  logic [15:0] ptr;
  logic       rd, mack;
  logic [PAGE_BYTES-1:0] pvalid;
  logic [BUSY_W-1:0] busy_cnt;
  logic [7:0] mem  [STORE_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire busy     = busy_cnt != '0;
  wire standby  = st == ST_IDLE;
  wire addr_hit = rx[7:4] == DEV_TYPE && rx[3:1] == strap_i && !busy;
  wire commit   = stop_det && st == ST_WR && |pvalid && !wp_i;
  wire byte_wr  = scl_fall && bcnt == 4'd8 && st == ST_WR;
  wire [7:0] rdat = mem[ptr[STORE_AW-1:0]];

  function automatic logic [STORE_AW-1:0] slot(input logic [8:0] pg, input int i);
    logic [15:0] w;
    w = {pg, i[6:0]};
    return w[STORE_AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s; sda_p <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cnt <= '0;
    else if (commit) busy_cnt <= BUSY_W'(WRITE_CYCLES);
    else if (busy) busy_cnt <= busy_cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (byte_wr) pbuf[ptr[PAGE_AW-1:0]] <= rx;
    if (commit)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[slot(ptr[15:7], i)] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bcnt <= '0; rx <= '0; tx <= '0; ptr <= '0;
      rd <= 1'b0; mack <= 1'b0; pvalid <= '0; sda_drive_low <= 1'b0;
    end else if (start_det) begin
      st <= ST_DEV; bcnt <= '0; sda_drive_low <= 1'b0; pvalid <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE; bcnt <= '0; sda_drive_low <= 1'b0; pvalid <= '0;
    end else if (!standby) begin
      if (scl_rise) begin
        if (bcnt < 4'd8) rx <= {rx[6:0], sda_s};
        else mack <= ~sda_s;
        bcnt <= bcnt + 1'b1;
      end else if (scl_fall) begin
        case (bcnt)
          4'd8: begin
            case (st)
              ST_DEV: if (addr_hit) begin
                        sda_drive_low <= 1'b1; rd <= rx[0];
                      end else st <= ST_IDLE;
              ST_AHI: begin sda_drive_low <= 1'b1; ptr[15:8] <= rx; st <= ST_ALO; end
              ST_ALO: begin sda_drive_low <= 1'b1; ptr[7:0] <= rx; st <= ST_WR; end
              ST_WR: begin
                sda_drive_low <= 1'b1;
                pvalid[ptr[PAGE_AW-1:0]] <= 1'b1;
                ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
              end
              default: sda_drive_low <= 1'b0;
            endcase
          end
          4'd9: begin
            bcnt <= '0;
            if ((st == ST_DEV && rd) || (st == ST_RD && mack)) begin
              st <= ST_RD;
              tx <= {rdat[6:0], 1'b0};
              sda_drive_low <= ~rdat[7];
              ptr <= ptr + 1'b1;
            end else begin
              sda_drive_low <= 1'b0;
              if (st == ST_DEV) st <= ST_AHI;
              else if (st == ST_RD) st <= ST_IDLE;
            end
          end
          default:
            if (st == ST_RD) begin
              sda_drive_low <= ~tx[7];
              tx <= {tx[6:0], 1'b0};
            end
        endcase
      end
    end
endmodule

// File: rtl/i2c_eeprom_slave_sva.sv
module i2c_eeprom_slave_sva #(parameter int BW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          drive,
  input logic          standby,
  input logic [BW-1:0] busy_cnt,
  input logic          commit,
  input logic          stop_det,
  input logic          wp,
  input logic [3:0]    bcnt
);
  a_r1_standby_released: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !drive);
  a_r10_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> !scl_s);
  a_r6_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && !commit) |=> busy_cnt == $past(busy_cnt) - 1'b1);
  a_r3_busy_only_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_cnt != '0) |-> $past(stop_det));
  a_r5_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && wp) |=> !$rose(busy_cnt != '0));
  a_r10_bit_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd9);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_sva #(.BW(BUSY_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_q[1]), .drive(sda_drive_low),
  .standby(standby), .busy_cnt(busy_cnt), .commit(commit),
  .stop_det(stop_det), .wp(wp_i), .bcnt(bcnt)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int WC = 600;
  localparam int H = 12;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_drive_low;
  wire  sda_line = !(m_low || sda_drive_low);
  int   n_run = 0, n_fail = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.STORE_AW(11), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_drive_low(sda_drive_low));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    repeat (2) @(negedge clk);
    m_low = !b;
    repeat (H) @(negedge clk);
    scl = 1'b1;
    repeat (H/2) @(negedge clk);
    s = sda_line;
    repeat (H/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic i2c_start();
    repeat (2) @(negedge clk);
    m_low = 1'b0;
    repeat (H) @(negedge clk);
    scl = 1'b1;
    repeat (H) @(negedge clk);
    m_low = 1'b1;
    repeat (H) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    repeat (2) @(negedge clk);
    m_low = 1'b1;
    repeat (H) @(negedge clk);
    scl = 1'b1;
    repeat (H) @(negedge clk);
    m_low = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); b[i] = s; end
    bit_xfer(!give_ack, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] a, input logic r);
    return {4'b1010, a, r};
  endfunction

  task automatic addr_phase(input logic [15:0] a, output logic ok);
    logic k0, k1, k2;
    i2c_start();
    send_byte(dev(STRAP, 1'b0), k0);
    send_byte(a[15:8], k1);
    send_byte(a[7:0], k2);
    ok = k0 && k1 && k2;
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, output logic ok);
    logic k;
    addr_phase(a, ok);
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); ok = ok && k; end
    i2c_stop();
  endtask

  task automatic read_tail(input int n);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic read_random(input logic [15:0] a, input int n, output logic ok);
    logic k;
    addr_phase(a, ok);
    i2c_start();
    send_byte(dev(STRAP, 1'b1), k);
    ok = ok && k;
    read_tail(n);
  endtask

  task automatic poll(output logic ack);
    i2c_start();
    send_byte(dev(STRAP, 1'b0), ack);
    i2c_stop();
  endtask

  task automatic settle();
    repeat (WC + 50) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 released after reset", {31'd0, sda_drive_low}, 32'd0);
  endtask

  task automatic t_mismatch();
    logic k;
    i2c_start();
    send_byte(dev(3'b100, 1'b0), k);
    chk("R1 strap mismatch not acked", {31'd0, k}, 32'd0);
    send_byte(dev(STRAP, 1'b0), k);
    chk("R1 bytes ignored until next start", {31'd0, k}, 32'd0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, STRAP, 1'b0}, k);
    chk("R1 wrong type code not acked", {31'd0, k}, 32'd0);
    i2c_stop();
  endtask

  task automatic t_byte_write_busy();
    logic ok, k;
    wbuf[0] = 8'hA5;
    write_seq(16'h0123, 1, ok);
    chk("R2 R3 address and data acked", {31'd0, ok}, 32'd1);
    poll(k);
    chk("R6 no ack while busy", {31'd0, k}, 32'd0);
    settle();
    poll(k);
    chk("R6 ack after busy period", {31'd0, k}, 32'd1);
    read_random(16'h0123, 1, ok);
    chk("R8 random read acks", {31'd0, ok}, 32'd1);
    chk("R8 random read data", {24'd0, rbuf[0]}, 32'hA5);
  endtask

  task automatic t_page_wrap();
    logic ok;
    wbuf[0] = 8'h5A;
    write_seq(16'h0280, 1, ok);
    settle();
    for (int i = 0; i < 12; i++) wbuf[i] = 8'h40 + 8'(i);
    write_seq(16'h0278, 12, ok);
    chk("R3 page data acked", {31'd0, ok}, 32'd1);
    settle();
    read_random(16'h0278, 8, ok);
    for (int i = 0; i < 8; i++)
      chk("R9 sequential read of page tail", {24'd0, rbuf[i]}, 32'h40 + i);
    chk("R9 released after nack", {31'd0, sda_drive_low}, 32'd0);
    read_random(16'h0200, 4, ok);
    for (int i = 0; i < 4; i++)
      chk("R4 wrap to page start", {24'd0, rbuf[i]}, 32'h48 + i);
    read_random(16'h0280, 1, ok);
    chk("R4 next page untouched", {24'd0, rbuf[0]}, 32'h5A);
  endtask

  task automatic t_protect();
    logic ok, k;
    wp = 1'b1;
    wbuf[0] = 8'h3C;
    write_seq(16'h0123, 1, ok);
    chk("R5 data acked under protect", {31'd0, ok}, 32'd1);
    poll(k);
    chk("R5 no busy under protect", {31'd0, k}, 32'd1);
    wp = 1'b0;
    read_random(16'h0123, 1, ok);
    chk("R5 array unchanged", {24'd0, rbuf[0]}, 32'hA5);
  endtask

  task automatic t_restart_discard();
    logic ok, k;
    addr_phase(16'h0123, ok);
    send_byte(8'h77, k);
    i2c_start();
    send_byte(dev(STRAP, 1'b0), k);
    chk("R3 no commit on repeated start", {31'd0, k}, 32'd1);
    i2c_stop();
    read_random(16'h0123, 1, ok);
    chk("R3 buffered byte discarded", {24'd0, rbuf[0]}, 32'hA5);
  endtask

  task automatic t_wrap_current();
    logic ok, k;
    wbuf[0] = 8'h22; wbuf[1] = 8'h33;
    write_seq(16'h0000, 2, ok);
    settle();
    wbuf[0] = 8'h11;
    write_seq(16'hFFFF, 1, ok);
    settle();
    read_random(16'hFFFF, 2, ok);
    chk("R7 read at 0xFFFF", {24'd0, rbuf[0]}, 32'h11);
    chk("R7 pointer wraps to 0x0000", {24'd0, rbuf[1]}, 32'h22);
    i2c_start();
    send_byte(dev(STRAP, 1'b1), k);
    read_tail(1);
    chk("R7 current address read", {24'd0, rbuf[0]}, 32'h33);
    read_random(16'h07FF, 1, ok);
    chk("R11 alias of 0xFFFF", {24'd0, rbuf[0]}, 32'h11);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mismatch();
    t_byte_write_busy();
    t_page_wrap();
    t_protect();
    t_restart_discard();
    t_wrap_current();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule